// File: doc/BRIEF.md
# SPI NOR Flash Command Sequencer

This block sits on the master side of a serial NOR flash. It turns a host request into the full sequence of flash transactions that the request needs. A request names an operation (read, sector erase or page program), a 24-bit byte address and a byte count. The sequencer first polls the flash status register until the device reports that it is idle. For erase and program it then sends a write-enable command in its own chip-select frame. It then sends the opcode and the address. Read and program requests go on to stream data bytes over a byte-wide handshake. A small internal mode-0 shifter produces the serial clock and data.

A request that runs past the configured device size, or that carries an unknown operation code, is refused before the bus is touched. If the flash stays busy for the configured number of status reads, the request ends with a timeout flag and no command frame is sent. Every request, good or bad, ends with a one-cycle `done` pulse. When `done` pulses, `xfer_count` gives the number of payload bytes moved, not counting the four header bytes.

Top module: `nor_cmd_seq`

## Requirements
- R1: After reset `spi_cs_n` is 1, `spi_sck` is 0, `req_ready` is 1 and `done` is 0.
- R2: The serial bus runs in mode 0. SCK stays low while chip select is high, and chip select is high whenever `req_ready` is high. Bytes are shifted MSB first, so every frame holds a whole number of 8-bit bytes.
- R3: Each accepted request starts with status polls. A poll is a frame holding opcode 0x05 and one dummy byte. Polls repeat, each in its own chip-select frame, until status bit 0 (busy) reads 0.
- R4: If POLL_MAX polls in a row all read busy, the request ends with `done` and `err_timeout` both high, and no frame follows the last poll.
- R5: Erase (`req_op`=1) and program (`req_op`=2) send a separate frame holding only opcode 0x06. This frame comes after the last poll and before the command frame.
- R6: The command frame is the opcode (0x03 read, 0xD8 erase, 0x02 program) followed by address bits 23:16, 15:8 and 7:0. An erase frame holds exactly these 4 bytes.
- R7: A read (`req_op`=0) clocks `req_len` data bytes in the same frame as its header. Each byte is presented on `rd_data` with a one-cycle `rd_valid` pulse, and `rd_valid` never pulses for erase or program.
- R8: A program sends `req_len` bytes in the same frame as its header. Each byte is taken from `wr_data` in a cycle where `wr_valid` and `wr_ready` are both high. The bus pauses while `wr_valid` is low.
- R9: A request is refused with `done` and `err_reject` both high, and no chip-select activity, in three cases: `req_op`=3; `req_addr`+`req_len` > DEV_BYTES for read or program; `req_addr` >= DEV_BYTES for erase. A read ending exactly at DEV_BYTES is accepted.
- R10: `done` is a single-cycle pulse. While `done` is high, `xfer_count` holds the number of payload bytes moved (0 for erase).
- R11: A read never sends the write-enable opcode 0x06.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle; a request is accepted in this cycle |
| req_op | input | 2 | 0 read, 1 sector erase, 2 page program, 3 invalid |
| req_addr | input | 24 | Byte address |
| req_len | input | LEN_W | Payload byte count (not used for erase) |
| wr_data | input | 8 | Program data byte |
| wr_valid | input | 1 | `wr_data` holds a byte |
| wr_ready | output | 1 | Sequencer takes a program byte in this cycle |
| rd_data | output | 8 | Read data byte |
| rd_valid | output | 1 | One-cycle pulse: `rd_data` holds a new byte |
| done | output | 1 | One-cycle pulse: request finished |
| err_reject | output | 1 | Pulses with `done`: request refused |
| err_timeout | output | 1 | Pulses with `done`: busy poll limit reached |
| xfer_count | output | LEN_W | Payload bytes moved by the last request |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The bound checker watches the bus rules on every cycle. These are: a low SCK while deselected, no frame open while the sequencer is idle, a single-cycle `done`, and error flags that always come with `done` and, for refusals, with no bus activity. The checker also confirms that `wr_ready` only rises inside a frame and that `rd_valid` only pulses after a read. Some behaviours need the bench's flash model, which decodes each frame: the order of frames (polls, write enable, command), the byte contents and address order, the poll count at the timeout limit, the exact data values, and the accepted boundary request.

// File: rtl/nor_seq_pkg.sv
// Shared encodings for the flash command sequencer.
// Assumes request codes 0..2 are operations and 3 is invalid.
package nor_seq_pkg;

    localparam logic [1:0] OP_READ  = 2'd0;
    localparam logic [1:0] OP_ERASE = 2'd1;
    localparam logic [1:0] OP_PROG  = 2'd2;

    localparam logic [7:0] CMD_WREN  = 8'h06;
    localparam logic [7:0] CMD_RDSR  = 8'h05;
    localparam logic [7:0] CMD_READ  = 8'h03;
    localparam logic [7:0] CMD_PROG  = 8'h02;
    localparam logic [7:0] CMD_ERASE = 8'hD8;

    typedef enum logic [2:0] {
        S_IDLE, S_POLL, S_WREN, S_CMD, S_DATA, S_GAP
    } seq_state_t;

    // Map a request code to the opcode of its main command frame.
    function automatic logic [7:0] main_opcode(input logic [1:0] op);
        case (op)
            OP_READ:  return CMD_READ;
            OP_ERASE: return CMD_ERASE;
            default:  return CMD_PROG;
        endcase
    endfunction

endpackage

// File: rtl/spi_byte_engine.sv
// Mode-0 byte shifter: sends one byte MSB first and captures one byte.
// Assumes start is only raised while busy is low; SCK idles low.
module spi_byte_engine #(
    parameter int SCK_HALF = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] tx_byte,
    input  logic       miso,
    output logic       sck,
    output logic       mosi,
    output logic       busy,
    output logic       done,
    output logic [7:0] rx_byte
);
    localparam int DIV_W = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1;

    logic [DIV_W-1:0] div_q;
    logic [2:0]       bit_q;
    logic [7:0]       tx_q;
    logic [7:0]       rx_q;

    // Bit timing: rise samples MISO, fall advances to the next bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
            bit_q <= '0;
            tx_q  <= '0;
            rx_q  <= '0;
            sck   <= 1'b0;
            busy  <= 1'b0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (start) begin
                    busy  <= 1'b1;
                    tx_q  <= tx_byte;
                    bit_q <= '0;
                    div_q <= '0;
                end
            end else if (div_q == DIV_W'(SCK_HALF - 1)) begin
                div_q <= '0;
                if (!sck) begin
                    sck  <= 1'b1;
                    rx_q <= {rx_q[6:0], miso};
                end else begin
                    sck <= 1'b0;
                    if (bit_q == 3'd7) begin
                        busy <= 1'b0;
                        done <= 1'b1;
                    end else begin
                        bit_q <= bit_q + 3'd1;
                        tx_q  <= {tx_q[6:0], 1'b0};
                    end
                end
            end else begin
                div_q <= div_q + DIV_W'(1);
            end
        end
    end

    assign mosi    = tx_q[7];
    assign rx_byte = rx_q;

endmodule

// File: rtl/nor_poll_counter.sv
// Counts busy status reads within one request.
// Assumes LIMIT >= 1; at_last is high when the next busy read is the final allowed one.
module nor_poll_counter #(
    parameter int LIMIT = 100000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic bump,
    output logic at_last
);
    localparam int CNT_W = $clog2(LIMIT + 1);

    logic [CNT_W-1:0] cnt_q;

    // Clear on a new request, advance on each busy read.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) cnt_q <= '0;
        else if (bump)       cnt_q <= cnt_q + CNT_W'(1);
    end

    assign at_last = (cnt_q == CNT_W'(LIMIT - 1));

endmodule

// File: rtl/nor_cmd_seq.sv
// Flash command sequencer: status poll, optional write enable, command
// frame with 24-bit address, then payload streaming.
// Assumes a single outstanding request; wr_data is stable while wr_valid is high.
module nor_cmd_seq
    import nor_seq_pkg::*;
#(
    parameter int DEV_BYTES = 1048576,
    parameter int LEN_W     = 21,
    parameter int POLL_MAX  = 100000,
    parameter int SCK_HALF  = 2,
    parameter int CS_GAP    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [1:0]       req_op,
    input  logic [23:0]      req_addr,
    input  logic [LEN_W-1:0] req_len,
    input  logic [7:0]       wr_data,
    input  logic             wr_valid,
    output logic             wr_ready,
    output logic [7:0]       rd_data,
    output logic             rd_valid,
    output logic             done,
    output logic             err_reject,
    output logic             err_timeout,
    output logic [LEN_W-1:0] xfer_count,
    output logic             spi_sck,
    output logic             spi_cs_n,
    output logic             spi_mosi,
    input  logic             spi_miso
);
    localparam int GAP_W = $clog2(CS_GAP + 1);

    seq_state_t       st_q, after_q;
    logic [1:0]       bidx_q;
    logic             launched_q, cs_act_q;
    logic [1:0]       op_q;
    logic [23:0]      addr_q;
    logic [LEN_W-1:0] left_q, cnt_q;
    logic [GAP_W-1:0] gap_q;

    logic       eng_start, eng_busy, eng_done;
    logic [7:0] eng_tx, eng_rx;
    logic       sending, data_ok, modifies, req_bad, poll_last, poll_bump;
    logic [32:0] span_end;

    // Request screening and byte launch conditions.
    always_comb begin
        span_end  = 33'(req_addr) + ((req_op == OP_ERASE) ? 33'd1 : 33'(req_len));
        req_bad   = (req_op == 2'd3) || (span_end > 33'(DEV_BYTES));
        modifies  = (op_q == OP_ERASE) || (op_q == OP_PROG);
        sending   = (st_q == S_POLL) || (st_q == S_WREN) || (st_q == S_CMD) || (st_q == S_DATA);
        data_ok   = !((st_q == S_DATA) && (op_q == OP_PROG)) || wr_valid;
        eng_start = sending && !launched_q && !eng_busy && data_ok;
        poll_bump = (st_q == S_POLL) && eng_done && (bidx_q == 2'd1) && eng_rx[0];
    end

    // Select the byte to shift out in the current frame position.
    always_comb begin
        eng_tx = 8'h00;
        case (st_q)
            S_POLL: eng_tx = (bidx_q == 2'd0) ? CMD_RDSR : 8'h00;
            S_WREN: eng_tx = CMD_WREN;
            S_CMD: begin
                case (bidx_q)
                    2'd0:    eng_tx = main_opcode(op_q);
                    2'd1:    eng_tx = addr_q[23:16];
                    2'd2:    eng_tx = addr_q[15:8];
                    default: eng_tx = addr_q[7:0];
                endcase
            end
            S_DATA: eng_tx = (op_q == OP_PROG) ? wr_data : 8'h00;
            default: eng_tx = 8'h00;
        endcase
    end

    // Request sequencing across poll, write-enable, command and data frames.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q        <= S_IDLE;
            after_q     <= S_IDLE;
            bidx_q      <= '0;
            launched_q  <= 1'b0;
            cs_act_q    <= 1'b0;
            op_q        <= OP_READ;
            addr_q      <= '0;
            left_q      <= '0;
            cnt_q       <= '0;
            gap_q       <= '0;
            done        <= 1'b0;
            err_reject  <= 1'b0;
            err_timeout <= 1'b0;
            rd_valid    <= 1'b0;
            rd_data     <= '0;
        end else begin
            done        <= 1'b0;
            err_reject  <= 1'b0;
            err_timeout <= 1'b0;
            rd_valid    <= 1'b0;
            if (eng_start) launched_q <= 1'b1;
            case (st_q)
                S_IDLE: if (req_valid) begin
                    op_q   <= req_op;
                    addr_q <= req_addr;
                    left_q <= req_len;
                    cnt_q  <= '0;
                    bidx_q <= '0;
                    if (req_bad) begin
                        done       <= 1'b1;
                        err_reject <= 1'b1;
                    end else begin
                        st_q     <= S_POLL;
                        cs_act_q <= 1'b1;
                    end
                end
                S_POLL: if (eng_done) begin
                    launched_q <= 1'b0;
                    if (bidx_q == 2'd0) begin
                        bidx_q <= 2'd1;
                    end else begin
                        cs_act_q <= 1'b0;
                        gap_q    <= '0;
                        if (!eng_rx[0]) begin
                            st_q    <= S_GAP;
                            after_q <= modifies ? S_WREN : S_CMD;
                        end else if (poll_last) begin
                            st_q        <= S_IDLE;
                            done        <= 1'b1;
                            err_timeout <= 1'b1;
                        end else begin
                            st_q    <= S_GAP;
                            after_q <= S_POLL;
                        end
                    end
                end
                S_WREN: if (eng_done) begin
                    launched_q <= 1'b0;
                    cs_act_q   <= 1'b0;
                    gap_q      <= '0;
                    after_q    <= S_CMD;
                    st_q       <= S_GAP;
                end
                S_CMD: if (eng_done) begin
                    launched_q <= 1'b0;
                    if (bidx_q != 2'd3) begin
                        bidx_q <= bidx_q + 2'd1;
                    end else if ((op_q != OP_ERASE) && (left_q != '0)) begin
                        st_q <= S_DATA;
                    end else begin
                        cs_act_q <= 1'b0;
                        done     <= 1'b1;
                        st_q     <= S_IDLE;
                    end
                end
                S_DATA: if (eng_done) begin
                    launched_q <= 1'b0;
                    cnt_q      <= cnt_q + LEN_W'(1);
                    left_q     <= left_q - LEN_W'(1);
                    if (op_q == OP_READ) begin
                        rd_valid <= 1'b1;
                        rd_data  <= eng_rx;
                    end
                    if (left_q == LEN_W'(1)) begin
                        cs_act_q <= 1'b0;
                        done     <= 1'b1;
                        st_q     <= S_IDLE;
                    end
                end
                S_GAP: begin
                    if (gap_q == GAP_W'(CS_GAP - 1)) begin
                        st_q     <= after_q;
                        cs_act_q <= 1'b1;
                        bidx_q   <= '0;
                    end else begin
                        gap_q <= gap_q + GAP_W'(1);
                    end
                end
                default: st_q <= S_IDLE;
            endcase
        end
    end

    spi_byte_engine #(.SCK_HALF(SCK_HALF)) u_engine (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (eng_start),
        .tx_byte (eng_tx),
        .miso    (spi_miso),
        .sck     (spi_sck),
        .mosi    (spi_mosi),
        .busy    (eng_busy),
        .done    (eng_done),
        .rx_byte (eng_rx)
    );

    nor_poll_counter #(.LIMIT(POLL_MAX)) u_poll (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   ((st_q == S_IDLE) && req_valid),
        .bump    (poll_bump),
        .at_last (poll_last)
    );

    assign req_ready  = (st_q == S_IDLE);
    assign wr_ready   = (st_q == S_DATA) && (op_q == OP_PROG) && !launched_q && !eng_busy;
    assign spi_cs_n   = !cs_act_q;
    assign xfer_count = cnt_q;

endmodule

// File: rtl/nor_cmd_seq_chk.sv
// Port-level protocol checker for nor_cmd_seq, attached by bind.
// Assumes it sees the same clock and reset as the sequencer.
module nor_cmd_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       req_ready,
    input logic [1:0] req_op,
    input logic       wr_ready,
    input logic       rd_valid,
    input logic       done,
    input logic       err_reject,
    input logic       err_timeout,
    input logic       spi_sck,
    input logic       spi_cs_n
);
    logic [1:0] last_op_q;

    // Remember the operation of the most recently accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n)                     last_op_q <= 2'd0;
        else if (req_valid && req_ready) last_op_q <= req_op;
    end

    AST_SCK_LOW_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sck); // R2
    AST_IDLE_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> spi_cs_n); // R2
    AST_TIMEOUT_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        err_timeout |-> (done && spi_cs_n && !err_reject)); // R4
    AST_RD_ONLY_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (last_op_q == 2'd0)); // R7
    AST_WR_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ready |-> !spi_cs_n); // R8
    AST_REJECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        err_reject |-> (done && spi_cs_n && $past(spi_cs_n))); // R9
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10

endmodule

bind nor_cmd_seq nor_cmd_seq_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_op      (req_op),
    .wr_ready    (wr_ready),
    .rd_valid    (rd_valid),
    .done        (done),
    .err_reject  (err_reject),
    .err_timeout (err_timeout),
    .spi_sck     (spi_sck),
    .spi_cs_n    (spi_cs_n)
);

// File: tb/nor_cmd_seq_bench.sv
// Directed bench with a behavioural serial flash model.
module nor_cmd_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int LEN_W      = 16;
    localparam int DEV        = 4096;
    localparam int PMAX       = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [1:0] req_op = 2'd0;
    logic [23:0] req_addr = '0;
    logic [LEN_W-1:0] req_len = '0;
    logic [7:0] wr_data = '0;
    logic wr_valid = 1'b0;
    logic req_ready, wr_ready, rd_valid, done, err_reject, err_timeout;
    logic [7:0] rd_data;
    logic [LEN_W-1:0] xfer_count;
    logic spi_sck, spi_cs_n, spi_mosi;
    logic spi_miso;

    always #(CLK_PERIOD/2) clk = ~clk;

    nor_cmd_seq #(.DEV_BYTES(DEV), .LEN_W(LEN_W), .POLL_MAX(PMAX),
                  .SCK_HALF(2), .CS_GAP(2)) u_nor_cmd_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_len(req_len),
        .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .rd_data(rd_data), .rd_valid(rd_valid), .done(done),
        .err_reject(err_reject), .err_timeout(err_timeout),
        .xfer_count(xfer_count), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    // ---------------- flash model ----------------
    int busy_cfg = 0;
    int busy_epoch = 0;
    int seen_epoch = 0;
    int busy_left = 0;
    logic prev_cs = 1'b1, prev_sck = 1'b0;
    logic [7:0] m_in = '0, m_out = '0, m_op = '0;
    logic [23:0] m_addr = '0;
    int m_bits = 0, m_bytes = 0, m_total = 0;
    logic m_skip = 1'b0;
    int n_txn = 0, n_csfall = 0, bad_align = 0;
    logic [7:0]  txn_op   [0:63];
    logic [23:0] txn_addr [0:63];
    int          txn_len  [0:63];
    logic [7:0]  prog_buf [0:15];

    // Decode frames on chip-select and serial-clock edges.
    always @(spi_sck or spi_cs_n) begin
        logic [7:0] nxt;
        if (busy_epoch != seen_epoch) begin
            busy_left  = busy_cfg;
            seen_epoch = busy_epoch;
        end
        if (prev_cs === 1'b1 && spi_cs_n === 1'b0) begin
            m_bits = 0; m_bytes = 0; m_total = 0; m_skip = 1'b0;
            m_out = '0; spi_miso = 1'b0; n_csfall++;
        end else if (prev_cs === 1'b0 && spi_cs_n === 1'b1) begin
            if (m_total != 0) begin
                if (m_total % 8 != 0) bad_align++;
                if (n_txn < 64) begin
                    txn_op[n_txn] = m_op; txn_addr[n_txn] = m_addr;
                    txn_len[n_txn] = m_bytes;
                end
                n_txn++;
            end
        end else if (spi_cs_n === 1'b0 && prev_sck === 1'b0 && spi_sck === 1'b1) begin
            m_in = {m_in[6:0], spi_mosi};
            m_bits++; m_total++;
            if (m_bits == 8) begin
                m_bits = 0;
                if (m_bytes == 0) m_op = m_in;
                else if (m_bytes <= 3) m_addr = {m_addr[15:0], m_in};
                if (m_op == 8'h02 && m_bytes >= 4 && m_bytes < 20) prog_buf[m_bytes-4] = m_in;
                nxt = 8'h00;
                if (m_op == 8'h05 && m_bytes == 0) begin
                    nxt = (busy_left > 0) ? 8'h03 : 8'h02;
                    if (busy_left > 0) busy_left--;
                end
                if (m_op == 8'h03 && m_bytes >= 3) nxt = (m_addr[7:0] + 8'(m_bytes - 3)) ^ 8'h5A;
                m_out = nxt; spi_miso = nxt[7]; m_skip = 1'b1;
                m_bytes++;
            end
        end else if (spi_cs_n === 1'b0 && prev_sck === 1'b1 && spi_sck === 1'b0) begin
            if (m_skip) m_skip = 1'b0;
            else begin m_out = {m_out[6:0], 1'b0}; spi_miso = m_out[7]; end
        end
        prev_cs = spi_cs_n; prev_sck = spi_sck;
    end

    // ---------------- observers ----------------
    logic [7:0] rd_buf [0:63];
    int rd_n = 0, n_done = 0;
    always @(negedge clk) begin
        if (rd_valid && rd_n < 64) begin rd_buf[rd_n] = rd_data; rd_n++; end
        if (done) n_done++;
    end

    int n_checks = 0, n_fail = 0;
    logic got_rej, got_to;
    logic [LEN_W-1:0] got_cnt;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic set_busy(input int n);
        busy_cfg = n; busy_epoch++;
    endtask

    task automatic do_req(input logic [1:0] op, input logic [23:0] a, input int len);
        @(negedge clk);
        req_op = op; req_addr = a; req_len = LEN_W'(len); req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(posedge clk); #1 req_valid = 1'b0;
        @(negedge clk);
        while (!done) @(negedge clk);
        got_rej = err_reject; got_to = err_timeout; got_cnt = xfer_count;
    endtask

    task automatic t_reset;
        chk("R1 cs_n", 32'(spi_cs_n), 1);
        chk("R1 sck", 32'(spi_sck), 0);
        chk("R1 req_ready", 32'(req_ready), 1);
        chk("R1 done", 32'(done), 0);
    endtask

    task automatic t_read;
        int t0 = n_txn, r0 = rd_n, d0 = n_done;
        set_busy(2);
        do_req(2'd0, 24'h000123, 3);
        repeat (4) @(negedge clk);
        chk("R3 frames", 32'(n_txn - t0), 4);
        for (int i = 0; i < 3; i++) begin
            chk("R3 poll op", 32'(txn_op[t0+i]), 32'h05);
            chk("R3 poll len", 32'(txn_len[t0+i]), 2);
        end
        chk("R11 no wren", 32'(txn_op[t0+3] == 8'h06), 0);
        chk("R6 read op", 32'(txn_op[t0+3]), 32'h03);
        chk("R6 read addr", 32'(txn_addr[t0+3]), 32'h000123);
        chk("R7 frame len", 32'(txn_len[t0+3]), 7);
        chk("R7 rd count", 32'(rd_n - r0), 3);
        for (int k = 0; k < 3; k++)
            chk("R7 rd data", 32'(rd_buf[r0+k]), 32'((8'h23 + 8'(k)) ^ 8'h5A));
        chk("R10 count", 32'(got_cnt), 3);
        chk("R10 one done", 32'(n_done - d0), 1);
        chk("R2 byte aligned", 32'(bad_align), 0);
    endtask

    task automatic t_erase;
        int t0 = n_txn;
        set_busy(0);
        do_req(2'd1, 24'h000800, 0);
        repeat (4) @(negedge clk);
        chk("R5 frames", 32'(n_txn - t0), 3);
        chk("R5 poll first", 32'(txn_op[t0]), 32'h05);
        chk("R5 wren", 32'(txn_op[t0+1]), 32'h06);
        chk("R5 wren len", 32'(txn_len[t0+1]), 1);
        chk("R6 erase op", 32'(txn_op[t0+2]), 32'hD8);
        chk("R6 erase addr", 32'(txn_addr[t0+2]), 32'h000800);
        chk("R6 erase len", 32'(txn_len[t0+2]), 4);
        chk("R10 erase count", 32'(got_cnt), 0);
    endtask

    task automatic t_prog;
        int t0 = n_txn;
        logic [7:0] pat [0:2];
        pat[0] = 8'hA1; pat[1] = 8'hB2; pat[2] = 8'hC3;
        set_busy(1);
        fork
            do_req(2'd2, 24'h000010, 3);
            begin
                for (int i = 0; i < 3; i++) begin
                    repeat (40) @(negedge clk);
                    wr_data = pat[i]; wr_valid = 1'b1;
                    while (!wr_ready) @(negedge clk);
                    @(posedge clk); #1 wr_valid = 1'b0;
                end
            end
        join
        repeat (4) @(negedge clk);
        chk("R5 prog frames", 32'(n_txn - t0), 4);
        chk("R5 prog wren", 32'(txn_op[t0+2]), 32'h06);
        chk("R6 prog op", 32'(txn_op[t0+3]), 32'h02);
        chk("R6 prog addr", 32'(txn_addr[t0+3]), 32'h000010);
        chk("R8 prog len", 32'(txn_len[t0+3]), 7);
        for (int k = 0; k < 3; k++) chk("R8 prog data", 32'(prog_buf[k]), 32'(pat[k]));
        chk("R10 prog count", 32'(got_cnt), 3);
    endtask

    task automatic t_timeout;
        int t0 = n_txn;
        set_busy(10);
        do_req(2'd1, 24'h000000, 0);
        repeat (200) @(negedge clk);
        chk("R4 timeout flag", 32'(got_to), 1);
        chk("R4 poll frames", 32'(n_txn - t0), PMAX);
        for (int i = 0; i < PMAX; i++) chk("R4 only polls", 32'(txn_op[t0+i]), 32'h05);
        set_busy(0);
    endtask

    task automatic t_range;
        int c0, t0;
        c0 = n_csfall;
        do_req(2'd0, 24'h000FFE, 3);
        chk("R9 over end", 32'(got_rej), 1);
        do_req(2'd1, 24'h001000, 0);
        chk("R9 erase past", 32'(got_rej), 1);
        do_req(2'd3, 24'h000000, 1);
        chk("R9 bad op", 32'(got_rej), 1);
        repeat (4) @(negedge clk);
        chk("R9 no cs activity", 32'(n_csfall - c0), 0);
        t0 = n_txn;
        do_req(2'd0, 24'h000FFE, 2);
        repeat (4) @(negedge clk);
        chk("R9 boundary ok", 32'(got_rej), 0);
        chk("R9 boundary frame", 32'(txn_len[t0+1]), 6);
        chk("R9 boundary count", 32'(got_cnt), 2);
    endtask

    initial begin
        bit timed_out = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        fork
            begin
                t_reset();
                t_read();
                t_erase();
                t_prog();
                t_timeout();
                t_range();
            end
            begin
                repeat (150000) @(posedge clk);
                timed_out = 1'b1;
            end
        join_any
        disable fork;
        if (timed_out) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule